// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a pipelined synchronous burst SRAM. It takes a new read, write or deselect command at every accepted rising clock edge and never needs idle cycles when reads and writes are mixed. Every input is captured in a register at the rising edge, and read data leaves through an output register. Write data is taken two accepted edges after its command. This lines the write data up with the read-data slot, so the pattern of data-bus direction follows the pattern of commands with no turnaround gap.

The data bus appears as separate `wdata`, `rdata` and `drv_en` signals. A clock enable freezes the whole pipeline, including the memory array. Three chip selects gate each newly loaded command. An advance/load input either starts a burst at an external address or steps the current burst through the low two address bits, in linear order or in interleaved order. A small array of configurable depth, organised in 9-bit byte lanes, stands in for the memory core. A read aimed at an address whose write has not yet reached the array returns the pending data, merged lane by lane.

Top module: `zt_sram`

## Requirements
- R1: A read command accepted at edge E produces `drv_en`=1 and the read data on `rdata` after the second accepted edge following E.
- R2: Reads, writes and deselects may be issued on consecutive accepted edges in any mix, with no wait states, and each one keeps its own timing.
- R3: A write takes `wdata` at the second accepted edge after its command. It updates only the lanes whose `byte_en` bit is 1, where bit i selects data bits [9i+8:9i].
- R4: A read of an address whose write has been issued but has not yet reached the array returns that write's data in the written lanes and the older contents in the other lanes.
- R5: An edge with `cke`=0 is ignored. `rdata`, `drv_en`, the pipeline, the burst state and the array all hold.
- R6: A load (`adv_ld`=0) is accepted only when `cs0`=1, `cs1`=1 and `cs2_n`=0. Any other combination is a deselect, which writes nothing and gives `drv_en`=0 two accepted edges later.
- R7: `drv_en` is 0 in the data slot of a write, that is, after the second accepted edge following the write command.
- R8: With `adv_ld`=1 the burst continues and inherits the read, write or deselect type of its load. The upper address bits stay fixed. The low two bits are start+n mod 4 when `burst_ilv` was 0 at the load, and start XOR n when it was 1, where n counts the advances since the load and wraps at 4.
- R9: After reset, `drv_en` and `rdata` are 0, the pipeline holds no command, and every array location reads 0.
- R10: `rdata` keeps its value at accepted edges that do not deliver read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; 0 ignores the edge |
| cs0 | input | 1 | Chip select, active high |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| wr | input | 1 | 1 write, 0 read (used on loads) |
| byte_en | input | LANES | Per-lane write select, active high |
| burst_ilv | input | 1 | Burst order on load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Load address |
| wdata | input | LANES*LANE_W | Write data, taken two accepted edges after the command |
| rdata | output | LANES*LANE_W | Registered read data |
| drv_en | output | 1 | Data-bus drive enable |

## Verification
A write's data slot and a read aimed at the same address can land in adjacent cycles. The read then finds the write still in the write buffer and not yet in the array, so forwarding and the byte-lane merge have to act together. The bench provokes this with directed write-then-read pairs using partial lane masks, and with random traffic confined to 16 addresses. It judges the result against a reference array in which each write is applied at its data slot. Clock-enable stalls are mixed into running bursts, so a frozen edge can also coincide with a pending forward.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Kind of command held in a pipeline slot.
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } kind_e;

    // Low two address bits of burst beat n.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] n,
                                             input logic       ilv);
        return ilv ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              adv_ld,
    input  logic              sel_ok,
    input  logic              wr,
    input  logic              ilv_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  kind_e             cur_kind,
    input  logic [ADDR_W-1:0] cur_base,
    input  logic [1:0]        cur_cnt,
    input  logic              cur_ilv,
    output kind_e             nxt_kind,
    output logic [ADDR_W-1:0] nxt_base,
    output logic [1:0]        nxt_cnt,
    output logic              nxt_ilv,
    output logic [ADDR_W-1:0] nxt_addr
);

    always_comb begin
        if (!adv_ld) begin
            // Load: chip selects decide whether this is a real command.
            if (sel_ok) begin
                nxt_kind = wr ? KIND_WRITE : KIND_READ;
            end else begin
                nxt_kind = KIND_NONE;
            end
            nxt_base = addr_in;
            nxt_cnt  = 2'd0;
            nxt_ilv  = ilv_in;
        end else begin
            // Advance: the type and the order are inherited from the load.
            nxt_kind = cur_kind;
            nxt_base = cur_base;
            nxt_cnt  = cur_cnt + 2'd1;
            nxt_ilv  = cur_ilv;
        end
        nxt_addr = {nxt_base[ADDR_W-1:2], burst_low(nxt_base[1:0], nxt_cnt, nxt_ilv)};
    end

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    // One storage column per byte lane, each written under its own select.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    cells[i] <= '0;
                end
            end else if (wr_en && wr_be[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/zt_rd_merge.sv
module zt_rd_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    pend_valid,
    input  logic [ADDR_W-1:0]       pend_addr,
    input  logic [LANES-1:0]        pend_be,
    input  logic [LANES*LANE_W-1:0] pend_data,
    output logic [LANES*LANE_W-1:0] merged
);

    logic hit;
    assign hit = pend_valid && (pend_addr == rd_addr);

    // Each lane independently takes the pending write or the array word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = (hit && pend_be[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : arr_data[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke,
    input  logic                    cs0,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    adv_ld,
    input  logic                    wr,
    input  logic [LANES-1:0]        byte_en,
    input  logic                    burst_ilv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drv_en
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        kind_e             kind;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              ilv;
    } burst_t;

    typedef struct packed {
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
    } cmd_t;

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } wbuf_t;

    typedef struct packed {
        burst_t            bst;
        cmd_t              st1;
        cmd_t              st2;
        wbuf_t             wb;
        logic [DATA_W-1:0] rdata;
        logic              drv;
    } state_t;

    state_t state_d, state_q;

    kind_e             seq_kind;
    logic [ADDR_W-1:0] seq_base;
    logic [1:0]        seq_cnt;
    logic              seq_ilv;
    logic [ADDR_W-1:0] seq_addr;
    logic              sel_ok;

    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] merged_rd;
    logic              commit_en;

    assign sel_ok = cs0 && cs1 && !cs2_n;

    zt_burst_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .adv_ld   (adv_ld),
        .sel_ok   (sel_ok),
        .wr       (wr),
        .ilv_in   (burst_ilv),
        .addr_in  (addr),
        .cur_kind (state_q.bst.kind),
        .cur_base (state_q.bst.base),
        .cur_cnt  (state_q.bst.cnt),
        .cur_ilv  (state_q.bst.ilv),
        .nxt_kind (seq_kind),
        .nxt_base (seq_base),
        .nxt_cnt  (seq_cnt),
        .nxt_ilv  (seq_ilv),
        .nxt_addr (seq_addr)
    );

    zt_mem_array #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_addr (state_q.wb.addr),
        .wr_be   (state_q.wb.be),
        .wr_data (state_q.wb.data),
        .rd_addr (state_q.st2.addr),
        .rd_data (arr_rd)
    );

    zt_rd_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .ADDR_W (ADDR_W)
    ) u_merge (
        .arr_data   (arr_rd),
        .rd_addr    (state_q.st2.addr),
        .pend_valid (state_q.wb.pend),
        .pend_addr  (state_q.wb.addr),
        .pend_be    (state_q.wb.be),
        .pend_data  (state_q.wb.data),
        .merged     (merged_rd)
    );

    always_comb begin
        state_d   = state_q;
        commit_en = 1'b0;
        if (cke) begin
            // Stage 1: new or continued command.
            state_d.bst.kind = seq_kind;
            state_d.bst.base = seq_base;
            state_d.bst.cnt  = seq_cnt;
            state_d.bst.ilv  = seq_ilv;
            state_d.st1.kind = seq_kind;
            state_d.st1.addr = seq_addr;
            state_d.st1.be   = byte_en;
            // Stage 2: delay so data lines up two edges after the command.
            state_d.st2      = state_q.st1;
            // Write data slot: capture the bus into the write buffer.
            state_d.wb.pend  = (state_q.st2.kind == KIND_WRITE);
            state_d.wb.addr  = state_q.st2.addr;
            state_d.wb.be    = state_q.st2.be;
            state_d.wb.data  = wdata;
            // The older buffered write retires into the array now.
            commit_en        = state_q.wb.pend;
            // Read data slot: output register and drive enable.
            state_d.drv      = (state_q.st2.kind == KIND_READ);
            if (state_q.st2.kind == KIND_READ) begin
                state_d.rdata = merged_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata  = state_q.rdata;
    assign drv_en = state_q.drv;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs0,
    input logic              cs1,
    input logic              cs2_n,
    input logic              adv_ld,
    input logic              wr,
    input logic [DATA_W-1:0] rdata,
    input logic              drv_en
);

    // Port-level shadow of command kinds: 0 none, 1 read, 2 write.
    logic [1:0] sh_burst, sh1, sh2, sh_new;

    always_comb begin
        if (adv_ld) begin
            sh_new = sh_burst;
        end else if (cs0 && cs1 && !cs2_n) begin
            sh_new = wr ? 2'd2 : 2'd1;
        end else begin
            sh_new = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_burst <= 2'd0;
            sh1      <= 2'd0;
            sh2      <= 2'd0;
        end else if (cke) begin
            sh_burst <= sh_new;
            sh1      <= sh_new;
            sh2      <= sh1;
        end
    end

    p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && sh2 == 2'd1) |=> drv_en);

    p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && sh2 == 2'd2) |=> !drv_en);

    p_desel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && sh2 == 2'd0) |=> !drv_en);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(rdata) && $stable(drv_en)));

    p_rdata_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && sh2 != 2'd1) |=> $stable(rdata));

endmodule

bind zt_sram zt_sram_chk #(
    .DATA_W (LANES*LANE_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .cs0    (cs0),
    .cs1    (cs1),
    .cs2_n  (cs2_n),
    .adv_ld (adv_ld),
    .wr     (wr),
    .rdata  (rdata),
    .drv_en (drv_en)
);

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int ADDR_W = 6;
    localparam int DW     = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b0, cs0 = 1'b0, cs1 = 1'b0, cs2_n = 1'b1;
    logic              adv_ld = 1'b0, wr = 1'b0, burst_ilv = 1'b0;
    logic [LANES-1:0]  byte_en = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              drv_en;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    zt_sram #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n),
        .adv_ld(adv_ld), .wr(wr), .byte_en(byte_en), .burst_ilv(burst_ilv),
        .addr(addr), .wdata(wdata), .rdata(rdata), .drv_en(drv_en)
    );

    // Reference model state. Kinds: 0 none, 1 read, 2 write.
    logic [DW-1:0]     m_mem [DEPTH];
    int                mb_kind = 0;
    logic [ADDR_W-1:0] mb_base = '0;
    logic [1:0]        mb_cnt = '0;
    logic              mb_ilv = 1'b0;
    int                p1_kind = 0, p2_kind = 0;
    logic [ADDR_W-1:0] p1_addr = '0, p2_addr = '0;
    logic [LANES-1:0]  p1_be = '0, p2_be = '0;
    logic [DW-1:0]     exp_rd = '0;
    logic              exp_drv = 1'b0;

    function automatic logic [1:0] f_low(logic [1:0] s, logic [1:0] n, logic ilv);
        return ilv ? (s ^ n) : (s + n);
    endfunction

    function automatic logic [DW-1:0] f_merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                              logic [LANES-1:0] be);
        logic [DW-1:0] r;
        r = old;
        for (int g = 0; g < LANES; g++) begin
            if (be[g]) r[g*LANE_W +: LANE_W] = nw[g*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, advance the model, check after the rising edge.
    task automatic step(input logic i_cke, input logic i_c0, input logic i_c1, input logic i_c2n,
                        input logic i_adv, input logic i_wr, input logic [LANES-1:0] i_be,
                        input logic i_ilv, input logic [ADDR_W-1:0] i_addr,
                        input logic [DW-1:0] i_wd);
        string t_drv, t_rd;
        @(negedge clk);
        cke = i_cke; cs0 = i_c0; cs1 = i_c1; cs2_n = i_c2n; adv_ld = i_adv; wr = i_wr;
        byte_en = i_be; burst_ilv = i_ilv; addr = i_addr; wdata = i_wd;
        if (i_cke) begin
            if (p2_kind == 1) begin
                exp_rd = m_mem[p2_addr];
                exp_drv = 1'b1;
                t_drv = "R1"; t_rd = "R1";
            end else begin
                exp_drv = 1'b0;
                t_drv = (p2_kind == 2) ? "R7" : "R6";
                t_rd = "R10";
            end
            if (p2_kind == 2) m_mem[p2_addr] = f_merge(m_mem[p2_addr], i_wd, p2_be);
            p2_kind = p1_kind; p2_addr = p1_addr; p2_be = p1_be;
            if (!i_adv) begin
                mb_kind = (i_c0 && i_c1 && !i_c2n) ? (i_wr ? 2 : 1) : 0;
                mb_base = i_addr; mb_cnt = 2'd0; mb_ilv = i_ilv;
            end else begin
                mb_cnt = mb_cnt + 2'd1;
            end
            p1_kind = mb_kind;
            p1_addr = {mb_base[ADDR_W-1:2], f_low(mb_base[1:0], mb_cnt, mb_ilv)};
            p1_be = i_be;
        end else begin
            t_drv = "R5"; t_rd = "R5";
        end
        @(posedge clk);
        #1;
        check(drv_en == exp_drv, t_drv, DW'(drv_en), DW'(exp_drv));
        check(rdata == exp_rd, t_rd, rdata, exp_rd);
    endtask

    task automatic ld(input logic i_wr, input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be,
                      input logic ilv, input logic [DW-1:0] wd);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, i_wr, be, ilv, a, wd);
    endtask

    task automatic adv(input logic [LANES-1:0] be, input logic [DW-1:0] wd);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, be, 1'b0, '0, wd);
    endtask

    task automatic stall(input logic [DW-1:0] wd);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 6'h3F, wd);
    endtask

    task automatic nop(input logic [DW-1:0] wd);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, '0, wd);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check(drv_en == 1'b0, "R9", DW'(drv_en), '0);
        check(rdata == '0, "R9", rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: an unwritten location reads zero.
        ld(1'b0, 6'd9, 4'h0, 1'b0, '0);
        nop('0); nop('0);

        // R4 and R3: write followed at once by a read of the same address.
        ld(1'b1, 6'd5, 4'hF, 1'b0, '0);
        ld(1'b0, 6'd5, 4'h0, 1'b0, '0);
        nop(36'h1_2345_6789);
        nop('0);
        ld(1'b1, 6'd5, 4'b0101, 1'b0, '0);
        ld(1'b0, 6'd5, 4'h0, 1'b0, '0);
        ld(1'b0, 6'd5, 4'h0, 1'b0, 36'hF_FFFF_FFFF);
        nop('0); nop('0);

        // R8: linear write burst from 2, stalled in the middle (R5), then interleaved read.
        ld(1'b1, 6'd14, 4'hF, 1'b0, '0);
        adv(4'hF, '0);
        stall(36'hA_AAAA_AAAA);
        adv(4'hF, 36'h0_0000_0011);
        adv(4'hF, 36'h0_0000_0022);
        stall(36'h5_5555_5555);
        nop(36'h0_0000_0033);
        nop(36'h0_0000_0044);
        ld(1'b0, 6'd13, 4'h0, 1'b1, '0);
        adv(4'h0, '0);
        stall('0);
        adv(4'h0, '0);
        adv(4'h0, '0);
        ld(1'b0, 6'd14, 4'h0, 1'b0, '0);
        adv(4'h0, '0); adv(4'h0, '0); adv(4'h0, '0);
        nop('0); nop('0);

        // R6: each chip select alone blocks a load; an advance after a deselect stays idle.
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 6'd20, '0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 6'd20, 36'h1_1111_1111);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 6'd20, 36'h2_2222_2222);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 6'd20, 36'h3_3333_3333);
        ld(1'b0, 6'd20, 4'h0, 1'b0, 36'h4_4444_4444);
        nop('0); nop('0);

        // R2: random back-to-back mix of reads, writes, bursts, stalls and deselects.
        void'($urandom(32'd1357));
        for (int n = 0; n < 4000; n++) begin
            logic r_cke, r_c0, r_c1, r_c2n;
            r_cke = ($urandom % 100) < 85;
            if (($urandom % 100) < 90) begin
                r_c0 = 1'b1; r_c1 = 1'b1; r_c2n = 1'b0;
            end else begin
                r_c0 = 1'($urandom); r_c1 = 1'($urandom); r_c2n = 1'($urandom);
            end
            step(r_cke, r_c0, r_c1, r_c2n, ($urandom % 100) < 40, 1'($urandom),
                 LANES'($urandom), 1'($urandom), ADDR_W'($urandom % 16),
                 {4'($urandom), 32'($urandom)});
        end
        nop('0); nop('0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule